// File: doc/BRIEF.md
# Per-Pin Interrupt Sense Controller

This block turns 32 general-purpose input pins into interrupt requests. Each pin passes through a two-stage synchronizer and is then compared against its previous synchronized sample. A 4-bit sense code per pin selects what counts as an event: a rising edge, a falling edge, a high level, a low level or either edge. A detected event is latched into a raw status bit only while the pin's input-enable bit is set. Latched bits stay set until software acknowledges them. They are then filtered by a per-pin unmask vector, and the filtered result drives two interrupt lines. One line covers pins 0 to 15 and the other covers pins 16 to 31.

Software reaches the block through a simple 32-bit register bus. Address bit 6 selects between two windows. The lower window holds the enable, unmask/mask strobe, status and acknowledge registers. The upper window holds four sense-configuration words. Reads are combinational and return zero for unmapped offsets. Writes take effect at the next clock edge. A typical service loop reads the masked status, acknowledges the lowest set bit and repeats until the masked status reads zero.

Top module: `intc_sense_unit`

## Requirements
- R1: After reset, every sense field, the enable register, the unmask vector and the raw status read as zero, and both interrupt lines are low.
- R2: Pin n's sense code lives in the upper-window word at byte offset 0x40 + 4*(n/8), bits 4*(n%8)+3 down to 4*(n%8). The word reads back exactly as written, and writing one word leaves the others unchanged.
- R3: Low three bits of a sense code: 0 = rising edge, 1 = falling edge, 2 = high level, 3 = low level, 4 = both edges. Bit 3 of the code does not change detection.
- R4: A sense code whose low three bits are 5, 6 or 7 never latches an event.
- R5: Offset 0x14 is a read/write enable register. A pin whose enable bit is 0 latches no new event, even while its level condition is active.
- R6: Writing 1 to bit n of offset 0x18 unmasks pin n, and writing 1 to bit n of offset 0x1C masks it. Zero bits in either write have no effect. A read of offset 0x18 returns the unmask vector.
- R7: Offset 0x20 reads the raw latched status. Offset 0x24 reads the raw status ANDed with the unmask vector.
- R8: Writing 1 to bit n of offset 0x28 clears pin n's status bit. An event detected in the same cycle wins, so an active level or a coinciding edge leaves the bit set.
- R9: irq_lo is the OR of masked status bits 0 to 15, and irq_hi is the OR of bits 16 to 31.
- R10: A pin change driven before clock edge k shows up in the raw status after edge k+2, and not before.
- R11: A latched status bit stays set after its pin condition goes away, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 32 | Asynchronous pin levels |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address; bit 6 selects the sense window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_lo | output | 1 | Interrupt for pins 0 to 15 |
| irq_hi | output | 1 | Interrupt for pins 16 to 31 |

## Verification
The acknowledge path and the capture path can both act on the same status bit in one cycle. The bench provokes this in two ways. First, it acknowledges a pin whose level condition is still present. Second, it times an acknowledge write so that it lands on the exact edge where a synchronized rising edge is latched, two cycles after the pin change. In both cases the status bit must read back as set. A second acknowledge, with no event pending, must then clear it.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int BUS_W           = 32;
  localparam int ADDR_W          = 7;
  localparam int FIELD_W         = 4;
  localparam int FIELDS_PER_WORD = BUS_W / FIELD_W;

  // word indices (byte offset / 4) in the lower window
  localparam logic [3:0] W_ENABLE = 4'd5;
  localparam logic [3:0] W_UNMASK = 4'd6;
  localparam logic [3:0] W_MASK   = 4'd7;
  localparam logic [3:0] W_RAW    = 4'd8;
  localparam logic [3:0] W_PEND   = 4'd9;
  localparam logic [3:0] W_ACK    = 4'd10;

  typedef enum logic [2:0] {
    SNS_RISE = 3'd0,
    SNS_FALL = 3'd1,
    SNS_HIGH = 3'd2,
    SNS_LOW  = 3'd3,
    SNS_BOTH = 3'd4
  } sense_kind_e;

  // event decision for one pin; bit 3 (async flag) uses the same detector
  function automatic logic sense_hit(input logic [FIELD_W-1:0] code,
                                     input logic cur, input logic prev);
    logic hit;
    case (code[2:0])
      SNS_RISE: hit = cur & ~prev;
      SNS_FALL: hit = ~cur & prev;
      SNS_HIGH: hit = cur;
      SNS_LOW:  hit = ~cur;
      SNS_BOTH: hit = cur ^ prev;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

  function automatic logic is_edge_code(input logic [FIELD_W-1:0] code);
    return (code[2:0] == SNS_RISE) || (code[2:0] == SNS_FALL) ||
           (code[2:0] == SNS_BOTH);
  endfunction
endpackage

// File: rtl/intc_sync.sv
`timescale 1ns/1ps
module intc_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/intc_detect.sv
`timescale 1ns/1ps
module intc_detect
  import intc_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PINS-1:0]         cur,
  input  logic [FIELD_W*PINS-1:0] sense,
  output logic [PINS-1:0]         evt
);
  logic [PINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    logic [FIELD_W-1:0] code;
    assign code   = sense[FIELD_W*g +: FIELD_W];
    assign evt[g] = sense_hit(code, cur[g], prev_q[g]);

    assert_edge_needs_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[g] && is_edge_code(code)) |-> (cur[g] != prev_q[g]));

    assert_bad_code_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (code[2:0] > 3'd4) |-> !evt[g]);
  end
endmodule

// File: rtl/intc_regfile.sv
`timescale 1ns/1ps
module intc_regfile
  import intc_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [BUS_W-1:0]        bus_wdata,
  output logic [BUS_W-1:0]        bus_rdata,
  input  logic [PINS-1:0]         evt,
  output logic [FIELD_W*PINS-1:0] sense,
  output logic [PINS-1:0]         unmask,
  output logic [PINS-1:0]         raw,
  output logic [PINS-1:0]         masked
);
  localparam int SREGS = PINS / FIELDS_PER_WORD;

  logic       wr_acc, rd_acc, hi_win;
  logic [3:0] word;
  logic       addr_unused;

  assign wr_acc      = bus_valid & bus_write;
  assign rd_acc      = bus_valid & ~bus_write;
  assign hi_win      = bus_addr[ADDR_W-1];
  assign word        = bus_addr[5:2];
  assign addr_unused = ^bus_addr[1:0];

  logic [PINS-1:0] en_q, unmask_q, raw_q;
  logic [FIELD_W*PINS-1:0] sense_q;
  logic [PINS-1:0] unmask_set, unmask_clr, ack_vec, cap_vec;

  function automatic logic [PINS-1:0] strobe(input logic hit, input logic [BUS_W-1:0] data);
    return hit ? data[PINS-1:0] : '0;
  endfunction

  assign unmask_set = strobe(wr_acc && !hi_win && word == W_UNMASK, bus_wdata);
  assign unmask_clr = strobe(wr_acc && !hi_win && word == W_MASK,   bus_wdata);
  assign ack_vec    = strobe(wr_acc && !hi_win && word == W_ACK,    bus_wdata);
  assign cap_vec    = evt & en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      unmask_q <= '0;
      raw_q    <= '0;
      sense_q  <= '0;
    end else begin
      if (wr_acc && !hi_win && word == W_ENABLE) en_q <= bus_wdata[PINS-1:0];
      unmask_q <= (unmask_q | unmask_set) & ~unmask_clr;
      raw_q    <= (raw_q & ~ack_vec) | cap_vec;
      if (wr_acc && hi_win) begin
        for (int k = 0; k < SREGS; k++) begin
          if (word == k[3:0]) sense_q[BUS_W*k +: BUS_W] <= bus_wdata;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      if (hi_win) begin
        for (int k = 0; k < SREGS; k++) begin
          if (word == k[3:0]) bus_rdata = sense_q[BUS_W*k +: BUS_W];
        end
      end else begin
        case (word)
          W_ENABLE: bus_rdata[PINS-1:0] = en_q;
          W_UNMASK: bus_rdata[PINS-1:0] = unmask_q;
          W_RAW:    bus_rdata[PINS-1:0] = raw_q;
          W_PEND:   bus_rdata[PINS-1:0] = raw_q & unmask_q;
          default:  bus_rdata = '0;
        endcase
      end
    end
  end

  assign sense  = sense_q;
  assign unmask = unmask_q;
  assign raw    = raw_q;
  assign masked = raw_q & unmask_q;

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vec != '0) |=> ((raw_q & $past(ack_vec & ~cap_vec)) == '0));

  assert_ack_loses_to_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_vec & cap_vec) != '0) |=> ((raw_q & $past(ack_vec & cap_vec)) == $past(ack_vec & cap_vec)));

  assert_mask_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (unmask_clr != '0) |=> ((unmask_q & $past(unmask_clr)) == '0));

  assert_unmask_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (unmask_set != '0) |=> ((~unmask_q & $past(unmask_set)) == '0));

  assert_disabled_no_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & ~en_q) != '0) |=> ((raw_q & ~$past(raw_q) & $past(evt & ~en_q)) == '0));
endmodule

// File: rtl/intc_sense_unit.sv
`timescale 1ns/1ps
module intc_sense_unit
  import intc_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PINS-1:0]    pin_in,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               irq_lo,
  output logic               irq_hi
);
  localparam int HALF  = PINS / 2;
  localparam int BANKS = 2;

  logic [PINS-1:0]         pin_sync, evt, unmask, raw, masked;
  logic [FIELD_W*PINS-1:0] sense;
  logic [BANKS-1:0]        irq_vec;

  intc_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync));

  intc_detect #(.PINS(PINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .cur(pin_sync), .sense(sense), .evt(evt));

  intc_regfile #(.PINS(PINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt(evt), .sense(sense), .unmask(unmask), .raw(raw), .masked(masked));

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign irq_vec[b] = |masked[b*HALF +: HALF];
  end

  assign irq_lo = irq_vec[0];
  assign irq_hi = irq_vec[1];

  assert_irq_lo_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> ((unmask[HALF-1:0] != '0) && (raw[HALF-1:0] != '0)));

  assert_irq_hi_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> ((unmask[PINS-1:HALF] != '0) && (raw[PINS-1:HALF] != '0)));
endmodule

// File: tb/intc_sense_unit_test.sv
`timescale 1ns/1ps
module intc_sense_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pin_in;
  logic        bus_valid, bus_write;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_lo, irq_hi;

  always #2.5 clk = ~clk;

  intc_sense_unit uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lo(irq_lo), .irq_hi(irq_hi));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // monitor: compares each read against the queued expectation
  always @(negedge clk) begin
    #1;
    if (bus_valid && !bus_write) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard: unexpected read actual 0x%08h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s: addr 0x%02h actual 0x%08h expected 0x%08h", t, bus_addr, bus_rdata, e);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic chk_pin(input logic act, input logic e, input string t);
    #1;
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", t, act, e);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin_in = '0;
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    step(4);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    chk_pin(irq_lo, 1'b0, "R1 irq_lo");
    chk_pin(irq_hi, 1'b0, "R1 irq_hi");
    rd(7'h14, 32'h0, "R1 enable");
    rd(7'h18, 32'h0, "R1 unmask");
    rd(7'h20, 32'h0, "R1 raw");
    rd(7'h24, 32'h0, "R1 masked");
    for (int k = 0; k < 4; k++) rd(7'h40 + 7'(4*k), 32'h0, "R1 sense");

    // R2 sense word placement and readback
    wr(7'h44, 32'h7654_3210);
    wr(7'h4C, 32'hFEDC_BA98);
    rd(7'h44, 32'h7654_3210, "R2 word1");
    rd(7'h4C, 32'hFEDC_BA98, "R2 word3");
    rd(7'h40, 32'h0, "R2 word0 untouched");
    wr(7'h44, 32'h0);
    wr(7'h4C, 32'h0);

    // R5 disabled pin ignores an edge
    wr(7'h40, 32'h0000_0008);
    pin_in = 32'h1;
    step(4);
    rd(7'h20, 32'h0, "R5 disabled edge");
    pin_in = 32'h0;
    step(4);

    // pins 0..4: async rise/fall/high/low/both, pin5 invalid (13), pin6 both (4), pin17 rise
    wr(7'h40, 32'h04DC_BA98);
    wr(7'h48, 32'h0000_0080);
    wr(7'h14, 32'h0002_007F);
    rd(7'h14, 32'h0002_007F, "R5 enable readback");
    step(3);
    rd(7'h20, 32'h0000_0008, "R3 low level");
    wr(7'h28, 32'hFFFF_FFFF);
    rd(7'h20, 32'h0000_0008, "R8 active level survives ack");

    pin_in = 32'h0002_007F;
    step(2);
    rd(7'h20, 32'h0000_0008, "R10 not before third edge");
    rd(7'h20, 32'h0002_005D, "R10 R3 R4 rising pattern");

    wr(7'h28, 32'hFFFF_FFFF);
    rd(7'h20, 32'h0000_0004, "R8 high level survives ack");
    rd(7'h24, 32'h0, "R7 masked while all masked");
    chk_pin(irq_lo, 1'b0, "R9 irq_lo masked");

    wr(7'h18, 32'h0000_0004);
    rd(7'h18, 32'h0000_0004, "R6 unmask readback");
    rd(7'h24, 32'h0000_0004, "R7 masked status");
    chk_pin(irq_lo, 1'b1, "R9 irq_lo raised");
    chk_pin(irq_hi, 1'b0, "R9 irq_hi quiet");

    wr(7'h1C, 32'h0000_0004);
    rd(7'h18, 32'h0, "R6 mask strobe");
    chk_pin(irq_lo, 1'b0, "R6 irq_lo after mask");

    pin_in = 32'h0;
    step(3);
    rd(7'h20, 32'h0000_005E, "R11 R3 falling pattern");
    wr(7'h28, 32'hFFFF_FFFF);
    rd(7'h20, 32'h0000_0008, "R8 ack all");

    wr(7'h18, 32'h0002_0000);
    pin_in = 32'h0002_0000;
    step(3);
    rd(7'h24, 32'h0002_0000, "R7 masked high half");
    rd(7'h20, 32'h0002_0008, "R7 raw high half");
    chk_pin(irq_hi, 1'b1, "R9 irq_hi raised");
    chk_pin(irq_lo, 1'b0, "R9 irq_lo quiet");

    wr(7'h1C, 32'h0);
    rd(7'h18, 32'h0002_0000, "R6 zero bits no effect");
    wr(7'h28, 32'h0002_0000);
    rd(7'h20, 32'h0000_0008, "R8 single ack");
    chk_pin(irq_hi, 1'b0, "R9 irq_hi cleared");

    // R8 ack lands on the capture edge
    pin_in = 32'h0002_0001;
    step(2);
    wr(7'h28, 32'h0000_0001);
    rd(7'h20, 32'h0000_0009, "R8 capture beats ack");
    wr(7'h28, 32'h0000_0001);
    rd(7'h20, 32'h0000_0008, "R8 ack without event");

    // R5 disabled level condition
    wr(7'h14, 32'h0);
    wr(7'h28, 32'hFFFF_FFFF);
    rd(7'h20, 32'h0, "R5 disabled level");
    rd(7'h14, 32'h0, "R5 enable cleared");

    step(3);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule